// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Priority Resolver

This block merges two chained eight-input interrupt units into one resolver with sixteen request lines. The lower unit (lines 8 to 15) reports upward through one pin of the upper unit (lines 0 to 7). That pin is called the cascade pin, and it is pin 2 by default. Request lines are driven by single-cycle raise and lower events. The block holds a request register and an in-service register for each unit. From these, the masks and the vector bases, it produces a registered pending flag and the vector that wins under the cascaded priority order.

A processor-side agent samples the vector and returns it on the acknowledge port. The block maps the vector back to a line and moves that line into service. A per-line trigger-type register decides whether the request is consumed at that point: a 0 bit marks the line as edge triggered and the request is cleared; a 1 bit marks it as level triggered and the request stays. The trigger-type registers are written through a byte port that drops the bits which may not be set. Masks, vector bases and the cascade word arrive as plain inputs.

Top module: `irq_cascade_resolver`

## Requirements
- R1: A raise event on line n (0..7) sets upper request bit n. A raise on line n (8..15) sets lower request bit n-8 and, in the same update, upper request bit 2.
- R2: A raise or lower event on line 2 acts on line 9. An event on a line of 16 or above leaves all state unchanged.
- R3: A lower event on an upper line clears its request bit. A lower event on a lower line clears lower bit n-8, and clears upper bit 2 only when no unmasked lower request remains.
- R4: The pending flag is 1 when (upper request AND NOT upper mask AND NOT cascade word) is nonzero. It is also 1 when upper mask bit 2 is 0 and (lower request AND NOT lower mask) is nonzero.
- R5: The winning line is chosen in this order: unmasked upper lines 0 and 1; then unmasked lower lines 8..15, only while upper mask bit 2 is 0; then unmasked upper lines 3..7. Inside each group the lowest index wins.
- R6: The vector output is the upper base plus n for an upper winner, and the lower base plus (n-8) for a lower winner. It is 0 when no line wins.
- R7: An acknowledged vector in [upper base, upper base+7] names upper line (vector minus base). Otherwise, a vector in [lower base, lower base+7] names lower line (vector AND 7)+8. A vector in neither window changes nothing.
- R8: Acknowledging an upper line that is requested and unmasked sets its in-service bit. The request bit is cleared only if the line's trigger-type bit is 0 (edge).
- R9: Acknowledging a lower line that is requested and unmasked sets lower in-service bit n-8 and upper in-service bit 2. It clears the lower request bit if that line's trigger-type bit is 0. It clears upper request bit 2 if upper trigger-type bit 2 is 0.
- R10: Both trigger-type registers reset to 0. A write (select 0 = upper, 1 = lower) stores data AND 0xF8 for the upper unit and data AND 0xDE for the lower unit. The stored values are visible on the read outputs.
- R11: After reset, all request and in-service bits, the pending flag and the vector are 0. The pending flag and the vector follow any event, acknowledge or input change at the next clock edge and not before it.
- R12: An acknowledge naming a line that is not requested, or is masked, leaves all request and in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Line event strobe |
| evt_raise | input | 1 | 1 = raise, 0 = lower |
| evt_line | input | 5 | Line number of the event |
| mst_mask | input | 8 | Upper unit mask (1 = masked) |
| slv_mask | input | 8 | Lower unit mask (1 = masked) |
| mst_base | input | 8 | Upper unit vector base |
| slv_base | input | 8 | Lower unit vector base |
| cascade_word | input | 8 | Upper pins wired to a lower unit |
| lvl_wr_en | input | 1 | Trigger-type write strobe |
| lvl_wr_sel | input | 1 | 0 = upper, 1 = lower |
| lvl_wr_data | input | 8 | Trigger-type write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| irq_pending | output | 1 | Registered pending flag |
| irq_vector | output | 8 | Registered winning vector |
| mst_req | output | 8 | Upper request register |
| slv_req | output | 8 | Lower request register |
| mst_isr | output | 8 | Upper in-service register |
| slv_isr | output | 8 | Lower in-service register |
| lvl_mst | output | 8 | Upper trigger-type register |
| lvl_slv | output | 8 | Lower trigger-type register |

## Verification
The bench builds the block with its default parameters: keep masks 0xF8 and 0xDE, cascade pin 2, alias from line 2 to line 9, and a five-bit line field. The five-bit line field lets the bench send events on lines 16 to 31 and show that they are dropped. The two keep masks fix which trigger-type bits can ever hold a level setting. Because upper bit 2 can never be set, a lower acknowledge always consumes the cascade request. Every lower line except 8 and 13 can be made level triggered. This lets the bench compare level and edge consumption on the lower unit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int UNIT_LINES = 8;
  localparam int TOTAL_LINES = 2 * UNIT_LINES;

  typedef struct packed {
    logic [UNIT_LINES-1:0] m_set;
    logic [UNIT_LINES-1:0] m_clr;
    logic [UNIT_LINES-1:0] s_set;
    logic [UNIT_LINES-1:0] s_clr;
    logic                  s_drop;
  } evt_effect_t;

  // vector lies inside the eight-entry window starting at base
  function automatic logic in_window(input logic [7:0] vec, input logic [7:0] base);
    logic [8:0] top;
    top = {1'b0, base} + 9'd7;
    return ({1'b0, vec} >= {1'b0, base}) && ({1'b0, vec} <= top);
  endfunction

  function automatic logic [7:0] make_vector(input logic [7:0] base, input logic [2:0] idx);
    return base + {5'd0, idx};
  endfunction

  // lowest set bit: {found, index}
  function automatic logic [3:0] lowest_set(input logic [UNIT_LINES-1:0] bits);
    logic [3:0] r;
    r = 4'd0;
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (bits[i]) r = {1'b1, 3'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_evt_decode.sv
module irqc_evt_decode
  import irqc_pkg::*;
#(
  parameter int LINE_W      = 5,
  parameter int CASCADE_PIN = 2,
  parameter int ALIAS_FROM  = 2,
  parameter int ALIAS_TO    = 9
) (
  input  logic              evt_valid,
  input  logic              evt_raise,
  input  logic [LINE_W-1:0] evt_line,
  output evt_effect_t       eff,
  output logic              evt_inrange
);

  logic [LINE_W-1:0] eff_line;

  always_comb begin
    eff      = '0;
    eff_line = (int'(evt_line) == ALIAS_FROM) ? LINE_W'(ALIAS_TO) : evt_line;
    evt_inrange = evt_valid && (int'(eff_line) < TOTAL_LINES);
    if (evt_inrange) begin
      if (int'(eff_line) < UNIT_LINES) begin
        if (evt_raise) eff.m_set[eff_line[2:0]] = 1'b1;
        else           eff.m_clr[eff_line[2:0]] = 1'b1;
      end else begin
        if (evt_raise) begin
          eff.s_set[eff_line[2:0]] = 1'b1;
          eff.m_set[CASCADE_PIN]   = 1'b1;
        end else begin
          eff.s_clr[eff_line[2:0]] = 1'b1;
          eff.s_drop               = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irqc_ack_decode.sv
module irqc_ack_decode
  import irqc_pkg::*;
(
  input  logic       ack_valid,
  input  logic [7:0] ack_vector,
  input  logic [7:0] mst_base,
  input  logic [7:0] slv_base,
  output logic       hit_mst,
  output logic       hit_slv,
  output logic [2:0] ack_idx
);

  logic       in_m;
  logic       in_s;
  logic [7:0] m_off;

  always_comb begin
    in_m    = in_window(ack_vector, mst_base);
    in_s    = in_window(ack_vector, slv_base);
    m_off   = ack_vector - mst_base;
    hit_mst = ack_valid && in_m;
    hit_slv = ack_valid && !in_m && in_s;
    ack_idx = in_m ? m_off[2:0] : ack_vector[2:0];
  end

endmodule

// File: rtl/irqc_prio_select.sv
module irqc_prio_select
  import irqc_pkg::*;
#(
  parameter int CASCADE_PIN = 2
) (
  input  logic [7:0] mreq,
  input  logic [7:0] mmask,
  input  logic [7:0] sreq,
  input  logic [7:0] smask,
  input  logic [7:0] cascade,
  input  logic [7:0] mbase,
  input  logic [7:0] sbase,
  output logic       pend,
  output logic [7:0] vec
);

  localparam logic [7:0] ABOVE_PIN = 8'((1 << CASCADE_PIN) - 1);
  localparam logic [7:0] BELOW_PIN = ~8'((2 << CASCADE_PIN) - 1);

  logic [7:0] m_live;
  logic [7:0] s_live;
  logic       s_open;
  logic [3:0] pick_hi;
  logic [3:0] pick_sl;
  logic [3:0] pick_lo;

  always_comb begin
    m_live  = mreq & ~mmask;
    s_live  = sreq & ~smask;
    s_open  = !mmask[CASCADE_PIN];
    pick_hi = lowest_set(m_live & ABOVE_PIN);
    pick_sl = lowest_set(s_live);
    pick_lo = lowest_set(m_live & BELOW_PIN);
    pend    = (|(m_live & ~cascade)) || (s_open && (|s_live));
    if (pick_hi[3])                vec = make_vector(mbase, pick_hi[2:0]);
    else if (s_open && pick_sl[3]) vec = make_vector(sbase, pick_sl[2:0]);
    else if (pick_lo[3])           vec = make_vector(mbase, pick_lo[2:0]);
    else                           vec = 8'd0;
  end

endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
  import irqc_pkg::*;
#(
  parameter int         LINE_W       = 5,
  parameter int         CASCADE_PIN  = 2,
  parameter int         ALIAS_FROM   = 2,
  parameter int         ALIAS_TO     = 9,
  parameter logic [7:0] MST_LVL_KEEP = 8'hF8,
  parameter logic [7:0] SLV_LVL_KEEP = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_raise,
  input  logic [LINE_W-1:0] evt_line,
  input  logic [7:0]        mst_mask,
  input  logic [7:0]        slv_mask,
  input  logic [7:0]        mst_base,
  input  logic [7:0]        slv_base,
  input  logic [7:0]        cascade_word,
  input  logic              lvl_wr_en,
  input  logic              lvl_wr_sel,
  input  logic [7:0]        lvl_wr_data,
  input  logic              ack_valid,
  input  logic [7:0]        ack_vector,
  output logic              irq_pending,
  output logic [7:0]        irq_vector,
  output logic [7:0]        mst_req,
  output logic [7:0]        slv_req,
  output logic [7:0]        mst_isr,
  output logic [7:0]        slv_isr,
  output logic [7:0]        lvl_mst,
  output logic [7:0]        lvl_slv
);

  evt_effect_t evt_eff;
  logic        evt_inrange;
  logic        hit_mst;
  logic        hit_slv;
  logic [2:0]  ack_idx;
  logic        ack_take_mst;
  logic        ack_take_slv;
  logic [7:0]  mreq_a, sreq_a, misr_n, sisr_n;
  logic [7:0]  mreq_n, sreq_n, mlvl_n, slvl_n;
  logic        pend_n;
  logic [7:0]  vec_n;

  irqc_evt_decode #(
    .LINE_W(LINE_W), .CASCADE_PIN(CASCADE_PIN),
    .ALIAS_FROM(ALIAS_FROM), .ALIAS_TO(ALIAS_TO)
  ) u_evt (
    .evt_valid(evt_valid), .evt_raise(evt_raise), .evt_line(evt_line),
    .eff(evt_eff), .evt_inrange(evt_inrange)
  );

  irqc_ack_decode u_ack (
    .ack_valid(ack_valid), .ack_vector(ack_vector),
    .mst_base(mst_base), .slv_base(slv_base),
    .hit_mst(hit_mst), .hit_slv(hit_slv), .ack_idx(ack_idx)
  );

  // acknowledge first, then line events on top of it
  always_comb begin
    ack_take_mst = hit_mst && mst_req[ack_idx] && !mst_mask[ack_idx];
    ack_take_slv = hit_slv && slv_req[ack_idx] && !slv_mask[ack_idx];
    mreq_a = mst_req;
    sreq_a = slv_req;
    misr_n = mst_isr;
    sisr_n = slv_isr;
    if (ack_take_mst) begin
      misr_n[ack_idx] = 1'b1;
      if (!lvl_mst[ack_idx]) mreq_a[ack_idx] = 1'b0;
    end
    if (ack_take_slv) begin
      sisr_n[ack_idx]     = 1'b1;
      misr_n[CASCADE_PIN] = 1'b1;
      if (!lvl_slv[ack_idx])     sreq_a[ack_idx]     = 1'b0;
      if (!lvl_mst[CASCADE_PIN]) mreq_a[CASCADE_PIN] = 1'b0;
    end
    sreq_n = (sreq_a | evt_eff.s_set) & ~evt_eff.s_clr;
    mreq_n = (mreq_a | evt_eff.m_set) & ~evt_eff.m_clr;
    if (evt_eff.s_drop && ((sreq_n & ~slv_mask) == 8'd0)) mreq_n[CASCADE_PIN] = 1'b0;
    mlvl_n = lvl_mst;
    slvl_n = lvl_slv;
    if (lvl_wr_en && !lvl_wr_sel) mlvl_n = lvl_wr_data & MST_LVL_KEEP;
    if (lvl_wr_en &&  lvl_wr_sel) slvl_n = lvl_wr_data & SLV_LVL_KEEP;
  end

  irqc_prio_select #(.CASCADE_PIN(CASCADE_PIN)) u_prio (
    .mreq(mreq_n), .mmask(mst_mask), .sreq(sreq_n), .smask(slv_mask),
    .cascade(cascade_word), .mbase(mst_base), .sbase(slv_base),
    .pend(pend_n), .vec(vec_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_req     <= '0;
      slv_req     <= '0;
      mst_isr     <= '0;
      slv_isr     <= '0;
      lvl_mst     <= '0;
      lvl_slv     <= '0;
      irq_pending <= 1'b0;
      irq_vector  <= '0;
    end else begin
      mst_req     <= mreq_n;
      slv_req     <= sreq_n;
      mst_isr     <= misr_n;
      slv_isr     <= sisr_n;
      lvl_mst     <= mlvl_n;
      lvl_slv     <= slvl_n;
      irq_pending <= pend_n;
      irq_vector  <= vec_n;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int         LINE_W       = 5,
  parameter int         CASCADE_PIN  = 2,
  parameter logic [7:0] MST_LVL_KEEP = 8'hF8,
  parameter logic [7:0] SLV_LVL_KEEP = 8'hDE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_raise,
  input logic [LINE_W-1:0] evt_line,
  input logic              ack_valid,
  input logic [7:0]        ack_vector,
  input logic [7:0]        mst_base,
  input logic [7:0]        slv_base,
  input logic              lvl_wr_en,
  input logic              irq_pending,
  input logic [7:0]        irq_vector,
  input logic [7:0]        mst_req,
  input logic [7:0]        slv_req,
  input logic [7:0]        mst_isr,
  input logic [7:0]        slv_isr,
  input logic [7:0]        lvl_mst,
  input logic [7:0]        lvl_slv
);

  logic slave_raise;
  logic high_line;
  logic stray_ack;

  always_comb begin
    slave_raise = evt_valid && evt_raise && (int'(evt_line) >= 8) && (int'(evt_line) < 16) && !ack_valid;
    high_line   = evt_valid && (int'(evt_line) >= 16) && !ack_valid;
    stray_ack   = ack_valid && !evt_valid && !irqc_pkg::in_window(ack_vector, mst_base)
                  && !irqc_pkg::in_window(ack_vector, slv_base);
  end

  p_slave_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slave_raise |=> (mst_req[CASCADE_PIN] && slv_req[$past(evt_line[2:0])]));

  p_high_line_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    high_line |=> ($stable(mst_req) && $stable(slv_req) && $stable(mst_isr) && $stable(slv_isr)));

  p_cascade_in_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|slv_isr) |-> mst_isr[CASCADE_PIN]);

  p_level_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_mst & ~MST_LVL_KEEP) == 8'd0) && ((lvl_slv & ~SLV_LVL_KEEP) == 8'd0));

  p_idle_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |-> (irq_vector == 8'd0));

  p_stray_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stray_ack |=> ($stable(mst_isr) && $stable(slv_isr)));

endmodule

bind irq_cascade_resolver irqc_checker #(
  .LINE_W(LINE_W), .CASCADE_PIN(CASCADE_PIN),
  .MST_LVL_KEEP(MST_LVL_KEEP), .SLV_LVL_KEEP(SLV_LVL_KEEP)
) u_irqc_checker (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_raise(evt_raise),
  .evt_line(evt_line), .ack_valid(ack_valid), .ack_vector(ack_vector),
  .mst_base(mst_base), .slv_base(slv_base), .lvl_wr_en(lvl_wr_en),
  .irq_pending(irq_pending), .irq_vector(irq_vector), .mst_req(mst_req),
  .slv_req(slv_req), .mst_isr(mst_isr), .slv_isr(slv_isr),
  .lvl_mst(lvl_mst), .lvl_slv(lvl_slv)
);

// File: tb/tb_irq_cascade_resolver.sv
module tb_irq_cascade_resolver;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       raise;
    logic [4:0] line;
    logic [7:0] m;
    logic [7:0] s;
    logic       pend;
    logic [7:0] vec;
  } row_t;

  // upper base 0x20, lower base 0x70, cascade word 0x04, no masks
  localparam row_t TBL [13] = '{
    '{1'b1, 5'd5,  8'h20, 8'h00, 1'b1, 8'h25},
    '{1'b1, 5'd12, 8'h24, 8'h10, 1'b1, 8'h74},
    '{1'b1, 5'd2,  8'h24, 8'h12, 1'b1, 8'h71},
    '{1'b1, 5'd1,  8'h26, 8'h12, 1'b1, 8'h21},
    '{1'b0, 5'd1,  8'h24, 8'h12, 1'b1, 8'h71},
    '{1'b0, 5'd9,  8'h24, 8'h10, 1'b1, 8'h74},
    '{1'b1, 5'd20, 8'h24, 8'h10, 1'b1, 8'h74},
    '{1'b0, 5'd12, 8'h20, 8'h00, 1'b1, 8'h25},
    '{1'b0, 5'd5,  8'h00, 8'h00, 1'b0, 8'h00},
    '{1'b1, 5'd15, 8'h04, 8'h80, 1'b1, 8'h77},
    '{1'b1, 5'd3,  8'h0C, 8'h80, 1'b1, 8'h77},
    '{1'b0, 5'd15, 8'h08, 8'h00, 1'b1, 8'h23},
    '{1'b0, 5'd3,  8'h00, 8'h00, 1'b0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0, evt_raise = 1'b0;
  logic [4:0] evt_line = '0;
  logic [7:0] mst_mask = '0, slv_mask = '0;
  logic [7:0] mst_base = 8'h20, slv_base = 8'h70, cascade_word = 8'h04;
  logic       lvl_wr_en = 1'b0, lvl_wr_sel = 1'b0;
  logic [7:0] lvl_wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [7:0] ack_vector = '0;
  logic       irq_pending;
  logic [7:0] irq_vector, mst_req, slv_req, mst_isr, slv_isr, lvl_mst, lvl_slv;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  irq_cascade_resolver dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_raise(evt_raise),
    .evt_line(evt_line), .mst_mask(mst_mask), .slv_mask(slv_mask),
    .mst_base(mst_base), .slv_base(slv_base), .cascade_word(cascade_word),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_sel(lvl_wr_sel), .lvl_wr_data(lvl_wr_data),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .mst_req(mst_req), .slv_req(slv_req),
    .mst_isr(mst_isr), .slv_isr(slv_isr), .lvl_mst(lvl_mst), .lvl_slv(lvl_slv)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic evt(input logic raise, input logic [4:0] line);
    evt_valid = 1'b1; evt_raise = raise; evt_line = line;
    step();
    evt_valid = 1'b0;
  endtask

  task automatic ack(input logic [7:0] v);
    ack_valid = 1'b1; ack_vector = v;
    step();
    ack_valid = 1'b0;
  endtask

  task automatic lvl_wr(input logic sel, input logic [7:0] d);
    lvl_wr_en = 1'b1; lvl_wr_sel = sel; lvl_wr_data = d;
    step();
    lvl_wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 and R10: reset state
    chk("R11 reset pending", {7'd0, irq_pending}, 8'h00);
    chk("R11 reset vector", irq_vector, 8'h00);
    chk("R11 reset requests", mst_req | slv_req, 8'h00);
    chk("R11 reset in-service", mst_isr | slv_isr, 8'h00);
    chk("R10 reset trigger types", lvl_mst | lvl_slv, 8'h00);

    // R1 R2 R3 R4 R5 R6: table of events
    for (int i = 0; i < 13; i++) begin
      evt(TBL[i].raise, TBL[i].line);
      chk($sformatf("R1/R2/R3 row %0d upper req", i), mst_req, TBL[i].m);
      chk($sformatf("R1/R2/R3 row %0d lower req", i), slv_req, TBL[i].s);
      chk($sformatf("R4 row %0d pending", i), {7'd0, irq_pending}, {7'd0, TBL[i].pend});
      chk($sformatf("R5/R6 row %0d vector", i), irq_vector, TBL[i].vec);
    end

    // R4 R5: mask interplay
    evt(1'b1, 5'd10);
    evt(1'b1, 5'd4);
    chk("R5 lower beats upper 4", irq_vector, 8'h72);
    mst_mask = 8'h04; step();
    chk("R5 cascade masked vector", irq_vector, 8'h24);
    chk("R4 cascade masked pending", {7'd0, irq_pending}, 8'h01);
    mst_mask = 8'h14; step();
    chk("R4 all blocked pending", {7'd0, irq_pending}, 8'h00);
    mst_mask = 8'h00; slv_mask = 8'h04; step();
    chk("R4 lower masked vector", irq_vector, 8'h24);
    slv_mask = 8'h00; step();

    // R10: trigger-type writes
    lvl_wr(1'b0, 8'hFF);
    chk("R10 upper keep mask", lvl_mst, 8'hF8);
    lvl_wr(1'b1, 8'hFF);
    chk("R10 lower keep mask", lvl_slv, 8'hDE);
    lvl_wr(1'b1, 8'h04);
    lvl_wr(1'b0, 8'h10);
    chk("R10 upper readback", lvl_mst, 8'h10);
    chk("R10 lower readback", lvl_slv, 8'h04);

    // R12: masked line acknowledge
    mst_mask = 8'h10;
    ack(8'h24);
    chk("R12 masked ack isr", mst_isr, 8'h00);
    chk("R12 masked ack req", mst_req, 8'h14);
    mst_mask = 8'h00;
    ack(8'h23);
    chk("R12 unrequested ack isr", mst_isr, 8'h00);

    // R8: level line acknowledge keeps request
    ack(8'h24);
    chk("R8 level ack isr", mst_isr, 8'h10);
    chk("R8 level ack req", mst_req, 8'h14);

    // R7: vector outside both windows
    ack(8'h50);
    chk("R7 stray ack upper isr", mst_isr, 8'h10);
    chk("R7 stray ack lower isr", slv_isr, 8'h00);

    // R9: lower level line acknowledge
    ack(8'h72);
    chk("R9 lower isr", slv_isr, 8'h04);
    chk("R9 upper isr pin", mst_isr, 8'h14);
    chk("R9 lower level req kept", slv_req, 8'h04);
    chk("R9 cascade req consumed", mst_req, 8'h10);

    // R8: edge line acknowledge consumes request
    evt(1'b1, 5'd6);
    ack(8'h26);
    chk("R8 edge ack isr", mst_isr, 8'h54);
    chk("R8 edge ack req", mst_req, 8'h10);

    // R9: lower edge line
    evt(1'b1, 5'd13);
    chk("R1 lower raise sets pin", mst_req, 8'h14);
    ack(8'h75);
    chk("R9 lower edge isr", slv_isr, 8'h24);
    chk("R9 lower edge req", slv_req, 8'h04);
    chk("R9 lower edge cascade", mst_req, 8'h10);

    // R11: one-edge latency
    evt_valid = 1'b1; evt_raise = 1'b1; evt_line = 5'd0;
    #1;
    chk("R11 vector before edge", irq_vector, 8'h72);
    step();
    evt_valid = 1'b0;
    chk("R11 vector after edge", irq_vector, 8'h20);

    // R6: base changes
    mst_base = 8'h40; step();
    chk("R6 upper base", irq_vector, 8'h40);
    evt(1'b0, 5'd0);
    slv_base = 8'h90; step();
    chk("R6 lower base", irq_vector, 8'h92);

    summary();
  end

endmodule